// File: doc/BRIEF.md
# Translation-Unit Control and Fault Register Bank

This block is the register bank between software and an address-translation datapath. Software reaches it through a plain 32-bit read/write port with registered read data. Through this port it turns translation on and off and programs a configuration word and a translation-table base. It can also request that traffic be held, and it can order a full or single-page invalidation of the translation cache.

The datapath reports faults as a valid strobe with a 3-bit class and the faulting address. Each class has its own pending bit. Each class also lands its address in one of four capture registers, grouped by page fault, write side, read side and bus error. Any pending fault raises the interrupt output and holds traffic blocked until software clears it. A hold becomes visible as a status bit only after a fixed drain interval, which models in-flight traffic finishing.

Top module: `xlat_ctl_regs`

## Requirements
- R1: After reset every writable register and the pending mask read 0, and `irq_o`, `xlat_en_o`, `block_req_o`, `flush_all_o` and `flush_page_o` are low.
- R2: The control word at byte offset 0x00 is 3 bits and reads back as written. Bit 0 drives `xlat_en_o` and bit 1 requests a hold on `block_req_o`: 0x5 enables, 0x7 enables and holds, and 0x0 disables. Rewriting 0x5 drops the hold request.
- R3: Status bit 0 at offset 0x08 reads 1 once `block_req_o` has been high for DRAIN_CYCLES consecutive clock edges. Before that it reads 0, and it reads 0 in any cycle where `block_req_o` is low.
- R4: A fault strobe with class n sets pending bit n of offset 0x18. The classes are 0 page fault, 1 read multi-hit, 2 write multi-hit, 3 bus error, 4 read security, 5 read access, 6 write security and 7 write protection. `irq_o` is high and `block_req_o` is high whenever any pending bit is set.
- R5: Writing a mask to offset 0x1C clears the pending bits set in the mask. A fault arriving in the same cycle as a clear of its own bit leaves that bit set. Writes to offset 0x18 change nothing.
- R6: A fault's address is captured on the fault strobe, but only if that class was not already pending. Classes 0 capture at 0x24, classes 2, 6 and 7 at 0x28, classes 1, 4 and 5 at 0x2C, and class 3 at 0x30.
- R7: Writing offset 0x0C with bit 0 set gives a one-cycle `flush_all_o` pulse in the cycle after the write. With bit 0 clear the write has no effect.
- R8: Writing offset 0x10 with bit 0 set gives a one-cycle `flush_page_o` pulse and presents bits [31:12] of the data on `flush_vpn_o`. With bit 0 clear the write has no effect.
- R9: Offset 0x34 reads the constant HW_REV, whose major number sits in bits [31:28]. Offsets 0x04 and 0x14 are full 32-bit read/write. Unmapped offsets read 0.
- R10: `bus_rdata_o` carries the addressed register in the cycle after a read access, and it holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel_i | input | 1 | Register access this cycle |
| bus_wr_i | input | 1 | 1 write, 0 read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| fault_valid_i | input | 1 | Fault strobe from datapath |
| fault_class_i | input | 3 | Fault class |
| fault_addr_i | input | 32 | Faulting address |
| xlat_en_o | output | 1 | Translation enable |
| block_req_o | output | 1 | Hold traffic request |
| irq_o | output | 1 | Fault interrupt |
| flush_all_o | output | 1 | Full invalidation pulse |
| flush_page_o | output | 1 | Single-page invalidation pulse |
| flush_vpn_o | output | 20 | Page number for single-page invalidation |
| cfg_o | output | 32 | Configuration word |
| table_base_o | output | 32 | Translation table base |

## Verification
The bench builds the block with DRAIN_CYCLES set to 3 and HW_REV set to 0x2000_0001. The short drain interval lets the bench poll status back to back and see the exact edge where the blocked bit first reads 1. A revision with both a major number and a non-zero low bit shows that the whole version word is returned, not only the major field. ADDR_W stays at 8, so every decoded offset and some unmapped ones can be reached.

// File: rtl/xlat_regs_pkg.sv
package xlat_regs_pkg;
  localparam int DW        = 32;
  localparam int NUM_FAULT = 8;
  localparam int NUM_SLOT  = 4;
  localparam int CLS_W     = $clog2(NUM_FAULT);
  localparam int SLOT_W    = $clog2(NUM_SLOT);

  typedef logic [DW-1:0] word_t;

  // word indices (byte offset / 4); software decodes these
  localparam int IX_CTRL  = 'h00;
  localparam int IX_CFG   = 'h01;
  localparam int IX_STAT  = 'h02;
  localparam int IX_FLALL = 'h03;
  localparam int IX_FLPG  = 'h04;
  localparam int IX_BASE  = 'h05;
  localparam int IX_PEND  = 'h06;
  localparam int IX_CLR   = 'h07;
  localparam int IX_CAP0  = 'h09;  // first of four capture slots
  localparam int IX_REV   = 'h0D;

  // capture slots: 0 page, 1 write side, 2 read side, 3 bus error
  function automatic logic [SLOT_W-1:0] slot_of(input logic [CLS_W-1:0] c);
    case (c)
      3'd0:                 slot_of = 2'd0;
      3'd2, 3'd6, 3'd7:     slot_of = 2'd1;
      3'd1, 3'd4, 3'd5:     slot_of = 2'd2;
      default:              slot_of = 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/xr_drain_timer.sv
module xr_drain_timer #(
  parameter int DRAIN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  output logic blocked_o
);
  localparam int CW = $clog2(DRAIN + 1);
  localparam logic [CW-1:0] LIM = CW'(DRAIN);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !req_i)   cnt_q <= '0;
    else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign blocked_o = req_i && (cnt_q == LIM);

  // R3: a freshly raised request is never already reported as held
  a_r3_not_instant: assert property (@(posedge clk) disable iff (rst)
    $rose(req_i) |-> !blocked_o);
  // R3: once held, the state persists while the request stays up
  a_r3_hold_persists: assert property (@(posedge clk) disable iff (rst)
    (req_i && $past(req_i) && $past(blocked_o)) |-> blocked_o);
endmodule

// File: rtl/xr_fault_bank.sv
module xr_fault_bank
  import xlat_regs_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ev_valid_i,
  input  logic [CLS_W-1:0]     ev_class_i,
  input  word_t                ev_addr_i,
  input  logic                 clr_i,
  input  logic [NUM_FAULT-1:0] clr_mask_i,
  output logic [NUM_FAULT-1:0] pending_o,
  output word_t                slot_addr_o [NUM_SLOT]
);
  logic [NUM_FAULT-1:0] set_vec, clr_vec;
  logic                 first_hit;

  always_comb begin
    set_vec = '0;
    if (ev_valid_i) set_vec[ev_class_i] = 1'b1;
    clr_vec = clr_i ? clr_mask_i : '0;
  end

  assign first_hit = ev_valid_i && !pending_o[ev_class_i];

  always_ff @(posedge clk) begin
    if (rst) pending_o <= '0;
    else     pending_o <= (pending_o & ~clr_vec) | set_vec;
  end

  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) slot_addr_o[s] <= '0;
      else if (first_hit && (slot_of(ev_class_i) == SLOT_W'(s)))
        slot_addr_o[s] <= ev_addr_i;
    end
  end

  // R4 / R5: a reported fault is pending on the next cycle, even against a clear
  a_r4_fault_sets: assert property (@(posedge clk) disable iff (rst)
    ev_valid_i |=> pending_o[$past(ev_class_i)]);
  // R5: a clear with no competing fault leaves the masked bits low
  a_r5_clear_works: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !ev_valid_i) |=> ((pending_o & $past(clr_mask_i)) == '0));
endmodule

// File: rtl/xlat_ctl_regs.sv
module xlat_ctl_regs
  import xlat_regs_pkg::*;
#(
  parameter int          ADDR_W       = 8,
  parameter int          DRAIN_CYCLES = 4,
  parameter logic [31:0] HW_REV       = 32'h2000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic              fault_valid_i,
  input  logic [2:0]        fault_class_i,
  input  logic [31:0]       fault_addr_i,
  output logic              xlat_en_o,
  output logic              block_req_o,
  output logic              irq_o,
  output logic              flush_all_o,
  output logic              flush_page_o,
  output logic [19:0]       flush_vpn_o,
  output logic [31:0]       cfg_o,
  output logic [31:0]       table_base_o
);
  localparam int IXW = ADDR_W - 2;

  logic [IXW-1:0]       widx;
  logic                 wr, rd;
  logic [2:0]           ctrl_q;
  logic [NUM_FAULT-1:0] pend;
  word_t                cap [NUM_SLOT];
  logic                 blocked;
  word_t                rmux;

  assign widx = bus_addr_i[ADDR_W-1:2];
  assign wr   = bus_sel_i && bus_wr_i;
  assign rd   = bus_sel_i && !bus_wr_i;

  function automatic logic at(input logic [IXW-1:0] i, input int k);
    return i == IXW'(k);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q       <= '0;
      cfg_o        <= '0;
      table_base_o <= '0;
      flush_all_o  <= 1'b0;
      flush_page_o <= 1'b0;
      flush_vpn_o  <= '0;
    end else begin
      flush_all_o  <= wr && at(widx, IX_FLALL) && bus_wdata_i[0];
      flush_page_o <= wr && at(widx, IX_FLPG)  && bus_wdata_i[0];
      if (wr && at(widx, IX_FLPG) && bus_wdata_i[0]) flush_vpn_o <= bus_wdata_i[31:12];
      if (wr && at(widx, IX_CTRL)) ctrl_q       <= bus_wdata_i[2:0];
      if (wr && at(widx, IX_CFG))  cfg_o        <= bus_wdata_i;
      if (wr && at(widx, IX_BASE)) table_base_o <= bus_wdata_i;
    end
  end

  xr_fault_bank u_faults (
    .clk        (clk),
    .rst        (rst),
    .ev_valid_i (fault_valid_i),
    .ev_class_i (fault_class_i),
    .ev_addr_i  (fault_addr_i),
    .clr_i      (wr && at(widx, IX_CLR)),
    .clr_mask_i (bus_wdata_i[NUM_FAULT-1:0]),
    .pending_o  (pend),
    .slot_addr_o(cap)
  );

  assign xlat_en_o   = ctrl_q[0];
  assign block_req_o = ctrl_q[1] || (|pend);
  assign irq_o       = |pend;

  xr_drain_timer #(.DRAIN(DRAIN_CYCLES)) u_drain (
    .clk      (clk),
    .rst      (rst),
    .req_i    (block_req_o),
    .blocked_o(blocked)
  );

  always_comb begin
    rmux = '0;
    if      (at(widx, IX_CTRL)) rmux = {29'd0, ctrl_q};
    else if (at(widx, IX_CFG))  rmux = cfg_o;
    else if (at(widx, IX_STAT)) rmux = {31'd0, blocked};
    else if (at(widx, IX_BASE)) rmux = table_base_o;
    else if (at(widx, IX_PEND)) rmux = {{(DW-NUM_FAULT){1'b0}}, pend};
    else if (at(widx, IX_REV))  rmux = HW_REV;
    else begin
      for (int s = 0; s < NUM_SLOT; s++)
        if (at(widx, IX_CAP0 + s)) rmux = cap[s];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     bus_rdata_o <= '0;
    else if (rd) bus_rdata_o <= rmux;
  end

  // R7: a full-invalidate pulse always follows a bus write
  a_r7_flush_from_write: assert property (@(posedge clk) disable iff (rst)
    flush_all_o |-> $past(wr));
  // R4: the interrupt only rises after a reported fault
  a_r4_irq_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(fault_valid_i));
  // R8: single-page and full pulses come from distinct writes
  a_r8_pulse_exclusive: assert property (@(posedge clk) disable iff (rst)
    flush_page_o |-> !flush_all_o);
endmodule

// File: tb/xlat_ctl_regs_bench.sv
`timescale 1ns/1ps
module xlat_ctl_regs_bench;
  localparam int DRAIN = 3;
  localparam logic [31:0] REV = 32'h2000_0001;

  logic clk = 0, rst = 1;
  logic bus_sel = 0, bus_wr = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic fault_valid = 0;
  logic [2:0] fault_class = 0;
  logic [31:0] fault_addr = 0;
  logic xlat_en, block_req, irq, flush_all, flush_page;
  logic [19:0] flush_vpn;
  logic [31:0] cfg, tbase;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  xlat_ctl_regs #(.ADDR_W(8), .DRAIN_CYCLES(DRAIN), .HW_REV(REV)) u_xlat_ctl_regs (
    .clk(clk), .rst(rst), .bus_sel_i(bus_sel), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .fault_valid_i(fault_valid),
    .fault_class_i(fault_class), .fault_addr_i(fault_addr), .xlat_en_o(xlat_en),
    .block_req_o(block_req), .irq_o(irq), .flush_all_o(flush_all), .flush_page_o(flush_page),
    .flush_vpn_o(flush_vpn), .cfg_o(cfg), .table_base_o(tbase));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic fault(input logic [2:0] c, input logic [31:0] a);
    fault_valid = 1; fault_class = c; fault_addr = a;
    @(posedge clk); @(negedge clk);
    fault_valid = 0;
  endtask

  function automatic logic [7:0] slot_ofs(input logic [2:0] c);
    case (c)
      3'd0: return 8'h24;
      3'd2, 3'd6, 3'd7: return 8'h28;
      3'd1, 3'd4, 3'd5: return 8'h2C;
      default: return 8'h30;
    endcase
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq", irq, 0); chk("R1 xlat_en", xlat_en, 0); chk("R1 block_req", block_req, 0);
    chk("R1 flush", {flush_all, flush_page}, 0);
    rd(8'h00, d); chk("R1 ctrl", d, 0);
    rd(8'h18, d); chk("R1 pending", d, 0);
    rd(8'h14, d); chk("R1 base", d, 0);
  endtask

  task automatic t_control();
    logic [31:0] d;
    wr(8'h00, 32'h5); chk("R2 enable", xlat_en, 1); chk("R2 no hold", block_req, 0);
    rd(8'h00, d); chk("R2 readback", d, 32'h5);
    wr(8'h00, 32'h7); chk("R2 hold req", block_req, 1); chk("R2 still enabled", xlat_en, 1);
    wr(8'h00, 32'h5); chk("R2 release", block_req, 0);
    wr(8'h00, 32'h0); chk("R2 disable", xlat_en, 0);
  endtask

  task automatic t_blocked();
    logic [31:0] d;
    wr(8'h00, 32'h7);
    // read i samples after i-1 edges of held request
    for (int i = 1; i <= DRAIN + 2; i++) begin
      rd(8'h08, d);
      chk("R3 drain timing", d, (i - 1 >= DRAIN) ? 32'h1 : 32'h0);
    end
    wr(8'h00, 32'h5);
    rd(8'h08, d); chk("R3 released", d, 0);
  endtask

  task automatic t_faults();
    logic [31:0] d;
    for (int c = 0; c < 8; c++) begin
      fault(3'(c), 32'hA000_0000 + 32'(c) * 32'h1111);
      chk("R4 irq", irq, 1); chk("R4 block", block_req, 1);
      rd(8'h18, d); chk("R4 pending bit", d, 32'(1) << c);
      rd(slot_ofs(3'(c)), d); chk("R6 capture", d, 32'hA000_0000 + 32'(c) * 32'h1111);
      wr(8'h18, 32'hFF);
      rd(8'h18, d); chk("R5 status write ignored", d, 32'(1) << c);
      wr(8'h1C, 32'(1) << c);
      chk("R5 irq cleared", irq, 0); chk("R4 block drops", block_req, 0);
    end
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    fault(3'd5, 32'h1234_5000);
    fault_valid = 1; fault_class = 3'd5; fault_addr = 32'h9999_9000;
    bus_sel = 1; bus_wr = 1; bus_addr = 8'h1C; bus_wdata = 32'h20;
    @(posedge clk); @(negedge clk);
    fault_valid = 0; bus_sel = 0; bus_wr = 0;
    rd(8'h18, d); chk("R5 set wins", d, 32'h20);
    rd(8'h2C, d); chk("R6 no overwrite while pending", d, 32'h1234_5000);
    fault(3'd5, 32'h5555_5000);
    rd(8'h2C, d); chk("R6 still held", d, 32'h1234_5000);
    fault(3'd0, 32'h0BAD_0000);
    rd(8'h18, d); chk("R4 two pending", d, 32'h21);
    wr(8'h1C, 32'h01);
    rd(8'h18, d); chk("R5 partial clear", d, 32'h20);
    wr(8'h1C, 32'hFF); chk("R5 all clear", irq, 0);
  endtask

  task automatic t_flush();
    wr(8'h0C, 32'h1); chk("R7 pulse", flush_all, 1);
    @(negedge clk); chk("R7 one cycle", flush_all, 0);
    wr(8'h0C, 32'h0); chk("R7 bit0 clear ignored", flush_all, 0);
    wr(8'h10, 32'hABCDE001);
    chk("R8 pulse", flush_page, 1); chk("R8 vpn", {12'd0, flush_vpn}, 32'hABCDE);
    chk("R8 not full", flush_all, 0);
    @(negedge clk); chk("R8 one cycle", flush_page, 0);
    wr(8'h10, 32'h12345000); chk("R8 bit0 clear ignored", flush_page, 0);
    chk("R8 vpn kept", {12'd0, flush_vpn}, 32'hABCDE);
  endtask

  task automatic t_misc();
    logic [31:0] d;
    rd(8'h34, d); chk("R9 version", d, REV); chk("R9 major", {28'd0, d[31:28]}, 32'h2);
    wr(8'h04, 32'hDEAD_BEEF); rd(8'h04, d); chk("R9 cfg", d, 32'hDEAD_BEEF);
    chk("R9 cfg port", cfg, 32'hDEAD_BEEF);
    wr(8'h14, 32'h8000_4000); rd(8'h14, d); chk("R9 base", d, 32'h8000_4000);
    rd(8'h20, d); chk("R9 unmapped", d, 0);
    rd(8'hFC, d); chk("R9 unmapped high", d, 0);
    rd(8'h34, d);
    wr(8'h04, 32'h0); @(negedge clk);
    chk("R10 rdata holds", bus_rdata, REV);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset(); t_control(); t_blocked(); t_faults(); t_set_wins(); t_flush(); t_misc();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule